// File: doc/BRIEF.md
# Priority Crossbar Pin Assigner

This block places the digital signals of a set of on-chip peripherals onto a 25-pin general-purpose I/O space. Each pin gets a single index: port number times eight plus bit number. Ports 0 to 2 are full bytes, and port 3 has only bit 0, which is pin 24. Software enables peripheral signal groups through a small register port. The block then walks through the enabled signals in a fixed priority order and gives each one the next pin that is not marked as skipped, starting at pin 0. Any pin that no signal claims falls back to general-purpose I/O and drives the value written to its output latch.

For every pin the block produces three outputs: a value, an output enable, and a qualifier that marks the pin as open-drain. Each pin's mode bit selects push-pull or open-drain drive. In the other direction, each peripheral signal receives the level of the pin it owns. The raw level of every pin can always be read back through the register port. Pin 24 also serves a debug data function: while the debug side drives it, that drive takes priority, and the pin is otherwise ordinary.

A status output shows when the enabled signals need more pins than remain unskipped. In that case the signals that do not fit are simply left unconnected.

Top module: `xbar_pin_assigner`

## Requirements
- R1: After reset, every enable is cleared, no pin is skipped, every pin is open-drain and every output latch holds 1. As a result, pins 0 to 23 have output enable low, `xbar_overflow` is low, and reads of registers 0 to 11 return 0.
- R2: The signal indices, highest priority first, are: 0 UART transmit, 1 UART receive, 2 SPI clock, 3 SPI master-in, 4 SPI master-out, 5 SPI select, 6 SMBus data, 7 SMBus clock, 8 comparator 0, 9 comparator 1, 10 system clock, 11 to 16 capture channels 0 to 5, 17 timer 0 input, 18 timer 1 input. The n-th enabled signal in this order owns the n-th unskipped pin, counting from pin 0.
- R3: The enable fields are as follows. Register 0: bit 0 UART, bit 1 SPI (signals 2 to 4), bit 2 SPI select (signal 5, only when bit 1 is also set), bit 3 SMBus. Register 1: bit 0 comparator 0, bit 1 comparator 1, bit 2 system clock, bit 3 timer 0, bit 4 timer 1. Register 2: bits 2:0 give the number of capture channels, and values above 6 act as 6.
- R4: Registers 4 to 7 hold one skip bit per pin, where bit b of register 4+k covers pin 8k+b. A skipped pin is never claimed and behaves as general-purpose I/O.
- R5: Registers 8 to 11 hold one mode bit per pin, with the same layout as R4 and 1 meaning push-pull. In push-pull mode the pin drives the source value with the source's enable and the open-drain qualifier is low. In open-drain mode the qualifier is high, the value is 0, and the enable is high only when the source enable is set and the source value is 0.
- R6: `xbar_overflow` is high exactly when some enabled signal found no unskipped pin left. Those signals own no pin.
- R7: An unclaimed pin takes its source value from the output latch and its source enable is 1. Writes to registers 12 to 15 set the latches, with the same bit layout as R4.
- R8: `periph_in[s]` equals the level on the pin that signal s owns, and it is 1 when s owns no pin.
- R9: A read request returns data on `cfg_rd_data` after the next clock edge. Registers 12 to 15 return the current pin levels, registers 0 to 11 return their stored fields, and every unused bit or address reads 0.
- R10: While `dbg_drive` is high, pin 24 is driven push-pull with `dbg_data`, whatever the crossbar or GPIO state. Its level stays readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register write address |
| cfg_wr_data | input | 8 | Register write data |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_rd_addr | input | 4 | Register read address |
| cfg_rd_data | output | 8 | Registered read data |
| periph_out | input | 19 | Output value of each peripheral signal |
| periph_oe | input | 19 | Output enable of each peripheral signal |
| periph_in | output | 19 | Pin level returned to each peripheral signal |
| pin_in | input | 25 | Level sensed at each pin |
| pin_out | output | 25 | Value driven on each pin |
| pin_oe | output | 25 | Output enable of each pin |
| pin_od | output | 25 | High when the pin is in open-drain mode |
| dbg_drive | input | 1 | Debug side takes over pin 24 |
| dbg_data | input | 1 | Debug value for pin 24 |
| xbar_overflow | output | 1 | Enabled signals exceed the available pins |

## Verification
The pin outputs and `periph_in` are combinational. They follow `periph_out`, `periph_oe`, `pin_in` and the debug inputs in the same cycle, and a register write changes them right after the edge that captures it. Read data appears one edge after the strobe. The bench drives inputs just after a rising edge and keeps its configuration mirror in step with that capturing edge. It compares every pin output, `periph_in` and the overflow flag against its model at each falling edge, and it checks read data just after the edge that registered it.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADR_EN_SER  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_EN_MISC = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_EN_CAP  = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_SKIP    = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_MODE    = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_LATCH   = 4'd12;

    // signal indices in priority order (highest first)
    localparam int SIG_UART_TX  = 0;
    localparam int SIG_UART_RX  = 1;
    localparam int SIG_SPI_SCK  = 2;
    localparam int SIG_SPI_MISO = 3;
    localparam int SIG_SPI_MOSI = 4;
    localparam int SIG_SPI_SEL  = 5;
    localparam int SIG_SMB_SDA  = 6;
    localparam int SIG_SMB_SCL  = 7;
    localparam int SIG_CMP0     = 8;
    localparam int SIG_CMP1     = 9;
    localparam int SIG_SYSCLK   = 10;
    localparam int SIG_CAP_BASE = 11;
    // signals that exist regardless of the capture channel count
    localparam int FIXED_SIGS   = 13;

    typedef struct packed {
        logic       uart;
        logic       spi;
        logic       spi_sel;
        logic       smbus;
        logic       cmp0;
        logic       cmp1;
        logic       sysclk;
        logic       tmr0;
        logic       tmr1;
        logic [2:0] cap_cnt;
    } xbar_en_t;

endpackage

// File: rtl/xbar_cfg_regs.sv
module xbar_cfg_regs
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = 25,
    parameter int PORT_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_PINS-1:0] pin_in,
    output xbar_en_t            en,
    output logic [NUM_PINS-1:0] skip,
    output logic [NUM_PINS-1:0] pp_mode,
    output logic [NUM_PINS-1:0] latch,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;

    typedef struct packed {
        xbar_en_t            en;
        logic [NUM_PINS-1:0] skip;
        logic [NUM_PINS-1:0] pp;
        logic [NUM_PINS-1:0] latch;
        logic [DATA_W-1:0]   rd;
    } state_t;

    localparam state_t STATE_RST = '{
        en:    '0,
        skip:  '0,
        pp:    '0,
        latch: '1,
        rd:    '0
    };

    state_t state_d, state_q;
    logic [DATA_W-1:0] rd_val;

    // read multiplexer
    always_comb begin
        rd_val = '0;
        if (rd_addr == ADR_EN_SER) begin
            rd_val[3:0] = {state_q.en.smbus, state_q.en.spi_sel,
                           state_q.en.spi, state_q.en.uart};
        end
        if (rd_addr == ADR_EN_MISC) begin
            rd_val[4:0] = {state_q.en.tmr1, state_q.en.tmr0, state_q.en.sysclk,
                           state_q.en.cmp1, state_q.en.cmp0};
        end
        if (rd_addr == ADR_EN_CAP) begin
            rd_val[2:0] = state_q.en.cap_cnt;
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int b = 0; b < PORT_W; b++) begin
                if (p * PORT_W + b < NUM_PINS) begin
                    if (rd_addr == ADR_SKIP + ADDR_W'(p))
                        rd_val[b] = state_q.skip[p*PORT_W+b];
                    if (rd_addr == ADR_MODE + ADDR_W'(p))
                        rd_val[b] = state_q.pp[p*PORT_W+b];
                    if (rd_addr == ADR_LATCH + ADDR_W'(p))
                        rd_val[b] = pin_in[p*PORT_W+b];
                end
            end
        end
    end

    // next-state computation
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wr_addr == ADR_EN_SER) begin
                state_d.en.uart    = wr_data[0];
                state_d.en.spi     = wr_data[1];
                state_d.en.spi_sel = wr_data[2];
                state_d.en.smbus   = wr_data[3];
            end
            if (wr_addr == ADR_EN_MISC) begin
                state_d.en.cmp0   = wr_data[0];
                state_d.en.cmp1   = wr_data[1];
                state_d.en.sysclk = wr_data[2];
                state_d.en.tmr0   = wr_data[3];
                state_d.en.tmr1   = wr_data[4];
            end
            if (wr_addr == ADR_EN_CAP) begin
                state_d.en.cap_cnt = wr_data[2:0];
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
                for (int b = 0; b < PORT_W; b++) begin
                    if (p * PORT_W + b < NUM_PINS) begin
                        if (wr_addr == ADR_SKIP + ADDR_W'(p))
                            state_d.skip[p*PORT_W+b] = wr_data[b];
                        if (wr_addr == ADR_MODE + ADDR_W'(p))
                            state_d.pp[p*PORT_W+b] = wr_data[b];
                        if (wr_addr == ADR_LATCH + ADDR_W'(p))
                            state_d.latch[p*PORT_W+b] = wr_data[b];
                    end
                end
            end
        end
        if (rd_en) begin
            state_d.rd = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STATE_RST;
        else        state_q <= state_d;
    end

    assign en      = state_q.en;
    assign skip    = state_q.skip;
    assign pp_mode = state_q.pp;
    assign latch   = state_q.latch;
    assign rd_data = state_q.rd;

endmodule

// File: rtl/xbar_assign.sv
module xbar_assign #(
    parameter  int NUM_PINS = 25,
    parameter  int NUM_SIG  = 19,
    localparam int SIG_W    = $clog2(NUM_SIG),
    localparam int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic [NUM_SIG-1:0]  sig_en,
    input  logic [NUM_PINS-1:0] skip,
    output logic [NUM_PINS-1:0] claimed,
    output logic [SIG_W-1:0]    owner [NUM_PINS],
    output logic [NUM_SIG-1:0]  sig_mapped,
    output logic [PIN_W-1:0]    sig_pin [NUM_SIG],
    output logic                overflow
);
    logic [SIG_W-1:0] order [NUM_SIG];
    int               n_en;

    // compact the enabled signal indices, keeping priority order
    always_comb begin
        n_en = 0;
        for (int s = 0; s < NUM_SIG; s++) order[s] = '0;
        for (int s = 0; s < NUM_SIG; s++) begin
            if (sig_en[s]) begin
                order[n_en] = SIG_W'(s);
                n_en = n_en + 1;
            end
        end
    end

    // hand the compacted list out to unskipped pins from pin 0 upward
    always_comb begin
        int used;
        used       = 0;
        sig_mapped = '0;
        claimed    = '0;
        for (int s = 0; s < NUM_SIG; s++) sig_pin[s] = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            owner[p] = '0;
            if (!skip[p] && used < n_en) begin
                owner[p]              = order[used];
                claimed[p]            = 1'b1;
                sig_mapped[order[used]] = 1'b1;
                sig_pin[order[used]]  = PIN_W'(p);
                used = used + 1;
            end
        end
        overflow = (used < n_en);
    end

endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux #(
    parameter  int NUM_PINS = 25,
    parameter  int NUM_SIG  = 19,
    localparam int SIG_W    = $clog2(NUM_SIG),
    localparam int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic [NUM_PINS-1:0] claimed,
    input  logic [SIG_W-1:0]    owner [NUM_PINS],
    input  logic [NUM_SIG-1:0]  sig_mapped,
    input  logic [PIN_W-1:0]    sig_pin [NUM_SIG],
    input  logic [NUM_PINS-1:0] pp_mode,
    input  logic [NUM_PINS-1:0] latch,
    input  logic [NUM_SIG-1:0]  periph_out,
    input  logic [NUM_SIG-1:0]  periph_oe,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                dbg_drive,
    input  logic                dbg_data,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_od,
    output logic [NUM_SIG-1:0]  periph_in
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam bit IS_DBG = (p == NUM_PINS - 1);
        logic src_val, src_oe, dbg_here;

        assign src_val  = claimed[p] ? periph_out[owner[p]] : latch[p];
        assign src_oe   = claimed[p] ? periph_oe[owner[p]]  : 1'b1;
        assign dbg_here = IS_DBG && dbg_drive;

        assign pin_out[p] = dbg_here ? dbg_data : (pp_mode[p] & src_val);
        assign pin_oe[p]  = dbg_here | (pp_mode[p] ? src_oe : (src_oe & ~src_val));
        assign pin_od[p]  = ~dbg_here & ~pp_mode[p];
    end

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
        assign periph_in[s] = sig_mapped[s] ? pin_in[sig_pin[s]] : 1'b1;
    end

endmodule

// File: rtl/xbar_pin_assigner.sv
module xbar_pin_assigner
    import xbar_pkg::*;
#(
    parameter  int PORT_W   = 8,
    parameter  int NUM_PINS = 25,
    parameter  int CAP_CH   = 6,
    localparam int NUM_SIG  = FIXED_SIGS + CAP_CH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [ADDR_W-1:0]   cfg_wr_addr,
    input  logic [DATA_W-1:0]   cfg_wr_data,
    input  logic                cfg_rd_en,
    input  logic [ADDR_W-1:0]   cfg_rd_addr,
    output logic [DATA_W-1:0]   cfg_rd_data,
    input  logic [NUM_SIG-1:0]  periph_out,
    input  logic [NUM_SIG-1:0]  periph_oe,
    output logic [NUM_SIG-1:0]  periph_in,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_od,
    input  logic                dbg_drive,
    input  logic                dbg_data,
    output logic                xbar_overflow
);
    localparam int SIG_W = $clog2(NUM_SIG);
    localparam int PIN_W = $clog2(NUM_PINS);

    xbar_en_t            cfg_en;
    logic [NUM_PINS-1:0] cfg_skip, cfg_pp, cfg_latch;
    logic [NUM_SIG-1:0]  sig_en, sig_mapped;
    logic [NUM_PINS-1:0] pin_claimed;
    logic [SIG_W-1:0]    pin_owner [NUM_PINS];
    logic [PIN_W-1:0]    sig_pin [NUM_SIG];
    logic [2:0]          cap_eff;

    xbar_cfg_regs #(.NUM_PINS(NUM_PINS), .PORT_W(PORT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .rd_en   (cfg_rd_en),
        .rd_addr (cfg_rd_addr),
        .pin_in  (pin_in),
        .en      (cfg_en),
        .skip    (cfg_skip),
        .pp_mode (cfg_pp),
        .latch   (cfg_latch),
        .rd_data (cfg_rd_data)
    );

    // per-signal enables in priority order
    assign cap_eff = (cfg_en.cap_cnt > 3'(CAP_CH)) ? 3'(CAP_CH) : cfg_en.cap_cnt;

    assign sig_en[SIG_UART_TX]  = cfg_en.uart;
    assign sig_en[SIG_UART_RX]  = cfg_en.uart;
    assign sig_en[SIG_SPI_SCK]  = cfg_en.spi;
    assign sig_en[SIG_SPI_MISO] = cfg_en.spi;
    assign sig_en[SIG_SPI_MOSI] = cfg_en.spi;
    assign sig_en[SIG_SPI_SEL]  = cfg_en.spi & cfg_en.spi_sel;
    assign sig_en[SIG_SMB_SDA]  = cfg_en.smbus;
    assign sig_en[SIG_SMB_SCL]  = cfg_en.smbus;
    assign sig_en[SIG_CMP0]     = cfg_en.cmp0;
    assign sig_en[SIG_CMP1]     = cfg_en.cmp1;
    assign sig_en[SIG_SYSCLK]   = cfg_en.sysclk;
    for (genvar c = 0; c < CAP_CH; c++) begin : g_cap
        assign sig_en[SIG_CAP_BASE+c] = (cap_eff > 3'(c));
    end
    assign sig_en[SIG_CAP_BASE+CAP_CH]   = cfg_en.tmr0;
    assign sig_en[SIG_CAP_BASE+CAP_CH+1] = cfg_en.tmr1;

    xbar_assign #(.NUM_PINS(NUM_PINS), .NUM_SIG(NUM_SIG)) u_assign (
        .sig_en     (sig_en),
        .skip       (cfg_skip),
        .claimed    (pin_claimed),
        .owner      (pin_owner),
        .sig_mapped (sig_mapped),
        .sig_pin    (sig_pin),
        .overflow   (xbar_overflow)
    );

    xbar_pin_mux #(.NUM_PINS(NUM_PINS), .NUM_SIG(NUM_SIG)) u_mux (
        .claimed    (pin_claimed),
        .owner      (pin_owner),
        .sig_mapped (sig_mapped),
        .sig_pin    (sig_pin),
        .pp_mode    (cfg_pp),
        .latch      (cfg_latch),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pin_in     (pin_in),
        .dbg_drive  (dbg_drive),
        .dbg_data   (dbg_data),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .pin_od     (pin_od),
        .periph_in  (periph_in)
    );

endmodule

// File: rtl/xbar_pin_assigner_chk.sv
module xbar_pin_assigner_chk
    import xbar_pkg::*;
#(
    parameter int NUM_PINS = 25
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_od,
    input logic                dbg_drive,
    input logic                dbg_data,
    input logic                overflow,
    input logic [NUM_PINS-1:0] claimed,
    input logic [NUM_PINS-1:0] skip,
    input logic [NUM_PINS-1:0] pp,
    input logic [NUM_PINS-1:0] latch
);
    logic [NUM_PINS-1:0] dbg_mask;
    assign dbg_mask = {dbg_drive, {(NUM_PINS-1){1'b0}}};

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe[NUM_PINS-2:0] == '0 && !overflow));

    a_r4_skip_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        (claimed & skip) == '0);

    a_r5_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_od & pin_out) == '0);

    a_r6_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> &(claimed | skip));

    a_r7_gpio_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (~claimed & pp & ~dbg_mask & (pin_out ^ latch)) == '0);

    a_r9_pin_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADR_LATCH) |=> rd_data == $past(pin_in[DATA_W-1:0]));

    a_r10_debug_drive: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_drive |-> (pin_oe[NUM_PINS-1] && !pin_od[NUM_PINS-1]
                       && pin_out[NUM_PINS-1] == dbg_data));

endmodule

bind xbar_pin_assigner xbar_pin_assigner_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (cfg_rd_en),
    .rd_addr   (cfg_rd_addr),
    .rd_data   (cfg_rd_data),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_od    (pin_od),
    .dbg_drive (dbg_drive),
    .dbg_data  (dbg_data),
    .overflow  (xbar_overflow),
    .claimed   (pin_claimed),
    .skip      (cfg_skip),
    .pp        (cfg_pp),
    .latch     (cfg_latch)
);

// File: tb/sim_xbar_pin_assigner.sv
module sim_xbar_pin_assigner;
    localparam int NP = 25;
    localparam int NS = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [3:0]    cfg_wr_addr = '0;
    logic [7:0]    cfg_wr_data = '0;
    logic          cfg_rd_en = 1'b0;
    logic [3:0]    cfg_rd_addr = '0;
    logic [7:0]    cfg_rd_data;
    logic [NS-1:0] periph_out = '0;
    logic [NS-1:0] periph_oe = '0;
    logic [NS-1:0] periph_in;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe, pin_od;
    logic          dbg_drive = 1'b0;
    logic          dbg_data = 1'b0;
    logic          xbar_overflow;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0]  sh_ser = '0, sh_misc = '0, sh_cap = '0;
    logic [31:0] sh_skip = '0, sh_pp = '0, sh_latch = 32'h01FF_FFFF;

    always #5 clk = ~clk;

    xbar_pin_assigner u0 (.*);

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference: queue of enabled signals handed to free pins
    task automatic model(output logic [NP-1:0] eo, output logic [NP-1:0] eoe,
                         output logic [NP-1:0] eod, output logic [NS-1:0] epi,
                         output logic eov);
        int q[$];
        int cnt;
        int own;
        logic v, oe;
        if (sh_ser[0]) begin q.push_back(0); q.push_back(1); end
        if (sh_ser[1]) begin q.push_back(2); q.push_back(3); q.push_back(4); end
        if (sh_ser[1] && sh_ser[2]) q.push_back(5);
        if (sh_ser[3]) begin q.push_back(6); q.push_back(7); end
        if (sh_misc[0]) q.push_back(8);
        if (sh_misc[1]) q.push_back(9);
        if (sh_misc[2]) q.push_back(10);
        cnt = (sh_cap[2:0] > 6) ? 6 : int'(sh_cap[2:0]);
        for (int c = 0; c < cnt; c++) q.push_back(11 + c);
        if (sh_misc[3]) q.push_back(17);
        if (sh_misc[4]) q.push_back(18);
        epi = '1;
        for (int p = 0; p < NP; p++) begin
            own = -1;
            if (!sh_skip[p] && q.size() > 0) own = q.pop_front();
            if (own >= 0) begin
                v = periph_out[own]; oe = periph_oe[own]; epi[own] = pin_in[p];
            end else begin
                v = sh_latch[p]; oe = 1'b1;
            end
            if (p == NP - 1 && dbg_drive) begin
                eo[p] = dbg_data; eoe[p] = 1'b1; eod[p] = 1'b0;
            end else if (sh_pp[p]) begin
                eo[p] = v; eoe[p] = oe; eod[p] = 1'b0;
            end else begin
                eo[p] = 1'b0; eoe[p] = oe & ~v; eod[p] = 1'b1;
            end
        end
        eov = (q.size() > 0);
    endtask

    function automatic logic [7:0] exp_rd(logic [3:0] a);
        logic [31:0] pv;
        pv = {7'b0, pin_in};
        case (a)
            4'd0:  return {4'b0, sh_ser[3:0]};
            4'd1:  return {3'b0, sh_misc[4:0]};
            4'd2:  return {5'b0, sh_cap[2:0]};
            4'd4, 4'd5, 4'd6, 4'd7:     return sh_skip[(int'(a)-4)*8 +: 8];
            4'd8, 4'd9, 4'd10, 4'd11:   return sh_pp[(int'(a)-8)*8 +: 8];
            4'd12, 4'd13, 4'd14, 4'd15: return pv[(int'(a)-12)*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    // per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NP-1:0] eo, eoe, eod;
            logic [NS-1:0] epi;
            logic eov;
            model(eo, eoe, eod, epi, eov);
            chk(pin_out === eo,  "R2 R7 pin_out", 64'(pin_out), 64'(eo));
            chk(pin_oe === eoe,  "R5 pin_oe", 64'(pin_oe), 64'(eoe));
            chk(pin_od === eod,  "R5 pin_od", 64'(pin_od), 64'(eod));
            chk(periph_in === epi, "R8 periph_in", 64'(periph_in), 64'(epi));
            chk(xbar_overflow === eov, "R6 overflow", 64'(xbar_overflow), 64'(eov));
        end
    end

    // all tasks start and end 1 time unit after a rising edge
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        step();
        cfg_wr_en = 1'b0;
        case (a)
            4'd0: sh_ser = d;
            4'd1: sh_misc = d;
            4'd2: sh_cap = d;
            4'd4, 4'd5, 4'd6, 4'd7:     sh_skip[(int'(a)-4)*8 +: 8] = d;
            4'd8, 4'd9, 4'd10, 4'd11:   sh_pp[(int'(a)-8)*8 +: 8] = d;
            4'd12, 4'd13, 4'd14, 4'd15: sh_latch[(int'(a)-12)*8 +: 8] = d;
            default: ;
        endcase
        sh_skip  &= 32'h01FF_FFFF;
        sh_pp    &= 32'h01FF_FFFF;
        sh_latch &= 32'h01FF_FFFF;
    endtask

    task automatic rd(logic [3:0] a, string req);
        logic [7:0] e;
        cfg_rd_en = 1'b1; cfg_rd_addr = a;
        e = exp_rd(a);
        step();
        cfg_rd_en = 1'b0;
        chk(cfg_rd_data === e, req, 64'(cfg_rd_data), 64'(e));
    endtask

    task automatic jiggle(int n);
        for (int i = 0; i < n; i++) begin
            periph_out = NS'($urandom);
            periph_oe  = NS'($urandom);
            pin_in     = NP'($urandom);
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1: reset state
        @(negedge clk);
        chk(pin_oe[NP-2:0] === '0, "R1 reset pin_oe", 64'(pin_oe), 64'(0));
        chk(xbar_overflow === 1'b0, "R1 reset overflow", 64'(xbar_overflow), 64'(0));
        step();
        for (int a = 0; a < 12; a++) rd(4'(a), "R1 reset register read");
        pin_in = NP'(25'h0A5_5A3C);
        rd(4'd12, "R9 pin level read port0");
        rd(4'd15, "R9 pin level read port3");

        // R3 and R2: UART alone takes pins 0 and 1
        wr(4'd0, 8'h01);
        wr(4'd8, 8'h03);
        periph_out[0] = 1'b1; periph_oe[0] = 1'b1;
        step();
        chk(pin_out[0] === 1'b1 && pin_oe[0] === 1'b1, "R2 uart tx on pin 0",
            64'({pin_out[0], pin_oe[0]}), 64'(3));
        jiggle(4);

        // R3: SPI without select, then with select
        wr(4'd0, 8'h03);
        pin_in[4] = 1'b0;
        step();
        chk(periph_in[4] === 1'b0, "R8 spi mosi sees pin 4", 64'(periph_in[4]), 64'(0));
        chk(periph_in[5] === 1'b1, "R3 spi select unmapped", 64'(periph_in[5]), 64'(1));
        jiggle(4);
        wr(4'd0, 8'h04);
        jiggle(3);
        wr(4'd0, 8'h07);
        jiggle(4);

        // R4: skipped pins are passed over
        wr(4'd4, 8'h05);
        pin_in[3] = 1'b0;
        step();
        chk(periph_in[1] === 1'b0, "R4 uart rx moves to pin 3", 64'(periph_in[1]), 64'(0));
        jiggle(4);

        // R3 capture count saturation, R6 overflow
        wr(4'd0, 8'h0F);
        wr(4'd1, 8'h1F);
        wr(4'd2, 8'h07);
        wr(4'd4, 8'h00);
        step();
        chk(xbar_overflow === 1'b0, "R6 all signals fit", 64'(xbar_overflow), 64'(0));
        jiggle(4);
        wr(4'd5, 8'hFF);
        step();
        chk(xbar_overflow === 1'b1, "R6 overflow when pins run out", 64'(xbar_overflow), 64'(1));
        jiggle(4);

        // R5 and R7: open-drain and GPIO latches
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd2, 8'h00);
        wr(4'd5, 8'h00);
        wr(4'd8, 8'h00);
        wr(4'd12, 8'h0F);
        step();
        chk(pin_oe[7:0] === 8'hF0, "R5 open-drain drives only zeros", 64'(pin_oe[7:0]), 64'(8'hF0));
        wr(4'd9, 8'hFF);
        wr(4'd13, 8'h3C);
        step();
        chk(pin_out[15:8] === 8'h3C, "R7 gpio latch value", 64'(pin_out[15:8]), 64'(8'h3C));
        jiggle(3);

        // R10: debug pin override
        dbg_drive = 1'b1; dbg_data = 1'b1;
        step();
        chk(pin_oe[24] === 1'b1 && pin_out[24] === 1'b1, "R10 debug drives pin 24",
            64'({pin_oe[24], pin_out[24]}), 64'(3));
        dbg_data = 1'b0;
        jiggle(3);
        rd(4'd15, "R10 pin 24 level readable");
        dbg_drive = 1'b0;

        // R9: read-back of every address
        for (int a = 0; a < 16; a++) rd(4'(a), "R9 register read");

        // randomized configurations
        for (int i = 0; i < 300; i++) begin
            wr(4'($urandom_range(0, 15)), 8'($urandom));
            jiggle(2);
            dbg_drive = 1'($urandom); dbg_data = 1'($urandom);
            if (i % 10 == 0) rd(4'($urandom_range(0, 15)), "R9 random read");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule